// File: doc/BRIEF.md
# ATA Device Task-File Register Interface

This block is the device end of a parallel ATA disk port. It runs on the system clock. The host drives two active-low chip selects, a 3-bit register address and active-low read and write strobes. The block answers on a 16-bit data bus. For each bit it supplies a value and a separate output enable, so the pad ring can build the three-state bus. Both strobes pass through a two-flop synchroniser. A write takes effect when its strobe is released. A read drives the bus for as long as the read strobe is held low.

The block holds the command parameter registers: features, sector count, sector number, cylinder low, cylinder high and device/head. It also holds the error byte, the status byte, the control byte (interrupt mask and soft reset) and a read-only drive-address view.

Data-register accesses work with a back-end through three interfaces:
- a read FIFO that the block pops;
- a write FIFO that the block pushes;
- a command strobe, which carries the command byte and the features byte.

The back-end reports completion with a one-clock done pulse. That pulse raises the interrupt request.

Top module: `ata_taskfile`

## Requirements
- R1: After reset, reading status (chip select 0, address 7) with an empty read FIFO returns 0x40. This means bit 6 ready = 1, and bit 7 busy, bit 3 data request and bit 0 error are all 0. After reset, the interrupt output is low and sector count reads 0.
- R2: Chip select 0 addresses 2 to 6 are sector count, sector number, cylinder low, cylinder high and device/head. Each is a byte that reads back the last value written. A read of any of them enables only bits 7:0 of the bus (enable mask 0x00FF).
- R3: At chip select 0, address 1 has two meanings. A write there loads features, which appears on `cmdFeat` and never changes the error byte. A read there returns the error byte. At the same chip select, address 7 reads status and writes command.
- R4: Under chip select 1, address 6 reads a copy of status and writes the control byte. Address 7 reads the drive-address value 0b1_hhhh_d_e on bits 6:0 with enable mask 0x007F, so bit 7 is never driven. In that value, hhhh is the inverted head bits 3:0, d is device/head bit 4 and e is its inverse. Every other chip select 1 address enables nothing on a read and ignores writes.
- R5: The address is invalid when both chip selects are low or both are high. On an invalid address the bus enable is 0 and writes change no register.
- R6: `iocs16N` is low only while chip select 0 alone is asserted with address 0. Bus bits 15:8 are enabled only in that case.
- R7: A data-register read drives all 16 bits (mask 0xFFFF) with the read-FIFO head. The block pops the FIFO once when the read ends. A read from an empty FIFO does not pop and sets error bit 0, which makes status bit 0 = 1.
- R8: A data-register write pushes its 16-bit word once when the write ends. A write while the FIFO is full does not push and sets error bit 1.
- R9: A command write gives one `cmdValid` pulse carrying the byte, sets busy (status 0xC0 with an empty FIFO) and clears the error byte. A later `cmdDone` clears busy and sets the pending interrupt.
- R10: A status read clears the pending interrupt. An alternate-status read returns the same value and leaves the interrupt set.
- R11: Control-byte bit 1 masks the interrupt output. The pending request survives the mask and reappears when the bit is cleared.
- R12: While control-byte bit 2 (soft reset) is 1, the following hold:
  - busy is set;
  - registers 1 to 6 are held at 0 and ignore writes;
  - the error byte and the pending interrupt are cleared.

  Writing the bit back to 0 clears busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cs0N | input | 1 | Command-block chip select, active low |
| cs1N | input | 1 | Control-block chip select, active low |
| da | input | 3 | Register address |
| diorN | input | 1 | Read strobe, active low |
| diowN | input | 1 | Write strobe, active low |
| ddIn | input | 16 | Data from the host bus |
| ddOut | output | 16 | Data toward the host bus |
| ddOe | output | 16 | Per-bit output enable for ddOut |
| iocs16N | output | 1 | 16-bit transfer indicator, active low |
| intrq | output | 1 | Interrupt request |
| cmdValid | output | 1 | One-clock command strobe |
| cmdByte | output | 8 | Command byte, valid with cmdValid |
| cmdFeat | output | 8 | Features byte |
| cmdDone | input | 1 | Back-end completion pulse |
| rdData | input | 16 | Read-FIFO head word |
| rdEmpty | input | 1 | Read FIFO empty |
| rdPop | output | 1 | Read-FIFO pop strobe |
| wrData | output | 16 | Word to the write FIFO |
| wrFull | input | 1 | Write FIFO full |
| wrPush | output | 1 | Write-FIFO push strobe |

## Verification
The hardest state to reach from the ports is a pending interrupt held under the mask. Bringing it about needs a command write, a back-end done pulse while the mask bit is set, and an alternate-status read that must not disturb it. The stimulus builds this in order:
1. Issue a command with the mask set.
2. Pulse done.
3. Read alternate status and check that the output stays low.
4. Clear the mask and check that the request reappears.
5. Read status and check that the request is gone.

FIFO underflow and overflow come from directed reads with the bench FIFO model drained and from writes with its full flag forced. Random register writes and random FIFO words run before and between these directed cases.

// File: rtl/ata_taskfile_pkg.sv
package ata_taskfile_pkg;

  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_ERRFEAT, SEL_COUNT, SEL_SECTOR,
    SEL_CYLLO, SEL_CYLHI, SEL_HEAD, SEL_STATCMD, SEL_ALTCTL, SEL_DEVADDR
  } regSelT;

  typedef struct packed {
    logic              rdStb;
    logic              wrStb;
    regSelT            sel;
    logic [DATA_W-1:0] wdata;
  } hostStbT;

  function automatic regSelT decodeSel(input logic cs0N, input logic cs1N,
                                       input logic [ADDR_W-1:0] da);
    regSelT s;
    s = SEL_NONE;
    if (!cs0N && cs1N) begin
      unique case (da)
        3'd0: s = SEL_DATA;
        3'd1: s = SEL_ERRFEAT;
        3'd2: s = SEL_COUNT;
        3'd3: s = SEL_SECTOR;
        3'd4: s = SEL_CYLLO;
        3'd5: s = SEL_CYLHI;
        3'd6: s = SEL_HEAD;
        default: s = SEL_STATCMD;
      endcase
    end else if (cs0N && !cs1N) begin
      if (da == 3'd6)      s = SEL_ALTCTL;
      else if (da == 3'd7) s = SEL_DEVADDR;
    end
    return s;
  endfunction

endpackage

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl
  import ata_taskfile_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cs0N,
  input  logic                    cs1N,
  input  logic [ADDR_W-1:0]       da,
  input  logic                    diorN,
  input  logic                    diowN,
  input  logic [DATA_W-1:0]       ddIn,
  output hostStbT                 stb
);

  // one extra stage past the synchroniser gives the previous level
  logic [SYNC_STAGES:0] rdSync, wrSync;
  logic   rdLvl, rdPrev, wrLvl, wrPrev;
  regSelT selQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdSync <= '1;
      wrSync <= '1;
    end else begin
      rdSync <= {rdSync[SYNC_STAGES-1:0], diorN};
      wrSync <= {wrSync[SYNC_STAGES-1:0], diowN};
    end
  end

  assign rdLvl  = rdSync[SYNC_STAGES-1];
  assign rdPrev = rdSync[SYNC_STAGES];
  assign wrLvl  = wrSync[SYNC_STAGES-1];
  assign wrPrev = wrSync[SYNC_STAGES];

  // address and data follow the pins while a synced strobe is low,
  // so the release edge acts on the last value seen during the access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= SEL_NONE;
      dataQ <= '0;
    end else if (!rdLvl || !wrLvl) begin
      selQ  <= decodeSel(cs0N, cs1N, da);
      dataQ <= ddIn;
    end
  end

  always_comb begin
    stb.rdStb = rdLvl && !rdPrev;
    stb.wrStb = wrLvl && !wrPrev;
    stb.sel   = selQ;
    stb.wdata = dataQ;
  end

  a_r7_rd_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdStb |=> !stb.rdStb);

endmodule

// File: rtl/ata_taskfile_dp.sv
module ata_taskfile_dp
  import ata_taskfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  hostStbT           stb,
  input  regSelT            rawSel,
  input  logic              rdActive,
  output logic [DATA_W-1:0] ddOut,
  output logic [DATA_W-1:0] ddOe,
  output logic              intrq,
  output logic              cmdValid,
  output logic [BYTE_W-1:0] cmdByte,
  output logic [BYTE_W-1:0] cmdFeat,
  input  logic              cmdDone,
  input  logic [DATA_W-1:0] rdData,
  input  logic              rdEmpty,
  output logic              rdPop,
  output logic [DATA_W-1:0] wrData,
  input  logic              wrFull,
  output logic              wrPush
);

  localparam logic [DATA_W-1:0] OE_WORD = '1;
  localparam logic [DATA_W-1:0] OE_BYTE = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
  localparam logic [DATA_W-1:0] OE_DEVA = OE_BYTE >> 1;
  localparam int PADW = DATA_W - BYTE_W;

  logic [BYTE_W-1:0] tfFeat, tfCount, tfSector, tfCylLo, tfCylHi, tfHead;
  logic [1:0]        errReg;
  logic              bsyCmd, intrPend, nIen, srst;
  logic              bsy, drq;
  logic [BYTE_W-1:0] statusByte;

  assign bsy        = bsyCmd || srst;
  assign drq        = !rdEmpty && !bsy;
  assign statusByte = {bsy, 1'b1, 2'b00, drq, 2'b00, |errReg};

  assign cmdValid = stb.wrStb && (stb.sel == SEL_STATCMD) && !srst;
  assign cmdByte  = stb.wdata[BYTE_W-1:0];
  assign cmdFeat  = tfFeat;
  assign wrData   = stb.wdata;
  assign wrPush   = stb.wrStb && (stb.sel == SEL_DATA) && !wrFull;
  assign rdPop    = stb.rdStb && (stb.sel == SEL_DATA) && !rdEmpty;
  assign intrq    = intrPend && !nIen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tfFeat <= '0; tfCount <= '0; tfSector <= '0;
      tfCylLo <= '0; tfCylHi <= '0; tfHead <= '0;
      errReg <= '0; bsyCmd <= 1'b0; intrPend <= 1'b0;
      nIen <= 1'b0; srst <= 1'b0;
    end else begin
      if (stb.wrStb && !srst) begin
        unique case (stb.sel)
          SEL_ERRFEAT: tfFeat   <= stb.wdata[BYTE_W-1:0];
          SEL_COUNT:   tfCount  <= stb.wdata[BYTE_W-1:0];
          SEL_SECTOR:  tfSector <= stb.wdata[BYTE_W-1:0];
          SEL_CYLLO:   tfCylLo  <= stb.wdata[BYTE_W-1:0];
          SEL_CYLHI:   tfCylHi  <= stb.wdata[BYTE_W-1:0];
          SEL_HEAD:    tfHead   <= stb.wdata[BYTE_W-1:0];
          default: ;
        endcase
      end
      if (stb.wrStb && (stb.sel == SEL_ALTCTL)) begin
        nIen <= stb.wdata[1];
        srst <= stb.wdata[2];
      end
      if (stb.rdStb && (stb.sel == SEL_STATCMD)) intrPend <= 1'b0;
      if (cmdDone && bsyCmd) begin
        bsyCmd   <= 1'b0;
        intrPend <= 1'b1;
      end
      if (cmdValid) begin
        bsyCmd   <= 1'b1;
        errReg   <= '0;
        intrPend <= 1'b0;
      end
      if (stb.rdStb && (stb.sel == SEL_DATA) && rdEmpty) errReg[0] <= 1'b1;
      if (stb.wrStb && (stb.sel == SEL_DATA) && wrFull)  errReg[1] <= 1'b1;
      if (srst) begin
        tfFeat <= '0; tfCount <= '0; tfSector <= '0;
        tfCylLo <= '0; tfCylHi <= '0; tfHead <= '0;
        errReg <= '0; bsyCmd <= 1'b0; intrPend <= 1'b0;
      end
    end
  end

  // read mux follows the raw pins so the bus is held for the whole strobe
  always_comb begin
    ddOut = '0;
    ddOe  = '0;
    if (rdActive) begin
      unique case (rawSel)
        SEL_DATA:    begin ddOut = rdData; ddOe = OE_WORD; end
        SEL_ERRFEAT: begin ddOut = {{(DATA_W-2){1'b0}}, errReg}; ddOe = OE_BYTE; end
        SEL_COUNT:   begin ddOut = {{PADW{1'b0}}, tfCount};  ddOe = OE_BYTE; end
        SEL_SECTOR:  begin ddOut = {{PADW{1'b0}}, tfSector}; ddOe = OE_BYTE; end
        SEL_CYLLO:   begin ddOut = {{PADW{1'b0}}, tfCylLo};  ddOe = OE_BYTE; end
        SEL_CYLHI:   begin ddOut = {{PADW{1'b0}}, tfCylHi};  ddOe = OE_BYTE; end
        SEL_HEAD:    begin ddOut = {{PADW{1'b0}}, tfHead};   ddOe = OE_BYTE; end
        SEL_STATCMD,
        SEL_ALTCTL:  begin ddOut = {{PADW{1'b0}}, statusByte}; ddOe = OE_BYTE; end
        SEL_DEVADDR: begin
          ddOut = {{(PADW+1){1'b0}}, 1'b1, ~tfHead[3:0], tfHead[4], ~tfHead[4]};
          ddOe  = OE_DEVA;
        end
        default: ;
      endcase
    end
  end

  a_r9_cmd_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);
  a_r9_busy_after_cmd: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> statusByte[7]);
  a_r7_one_pop: assert property (@(posedge clk) disable iff (!rstN)
    rdPop |=> !rdPop);
  a_r8_one_push: assert property (@(posedge clk) disable iff (!rstN)
    wrPush |=> !wrPush);
  a_r10_status_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdStb && stb.sel == SEL_STATCMD && !cmdDone) |=> !intrq);
  a_r12_srst_holds_clear: assert property (@(posedge clk) disable iff (!rstN)
    srst |=> (tfCount == '0 && tfHead == '0));
  a_r4_bit7_float: assert property (@(posedge clk) disable iff (!rstN)
    (rdActive && rawSel == SEL_DEVADDR) |-> !ddOe[BYTE_W-1]);

endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_taskfile_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs0N,
  input  logic              cs1N,
  input  logic [ADDR_W-1:0] da,
  input  logic              diorN,
  input  logic              diowN,
  input  logic [DATA_W-1:0] ddIn,
  output logic [DATA_W-1:0] ddOut,
  output logic [DATA_W-1:0] ddOe,
  output logic              iocs16N,
  output logic              intrq,
  output logic              cmdValid,
  output logic [BYTE_W-1:0] cmdByte,
  output logic [BYTE_W-1:0] cmdFeat,
  input  logic              cmdDone,
  input  logic [DATA_W-1:0] rdData,
  input  logic              rdEmpty,
  output logic              rdPop,
  output logic [DATA_W-1:0] wrData,
  input  logic              wrFull,
  output logic              wrPush
);

  hostStbT stb;
  regSelT  rawSel;

  assign rawSel  = decodeSel(cs0N, cs1N, da);
  assign iocs16N = (rawSel != SEL_DATA);

  ata_taskfile_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cs0N(cs0N), .cs1N(cs1N), .da(da),
    .diorN(diorN), .diowN(diowN), .ddIn(ddIn), .stb(stb)
  );

  ata_taskfile_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rawSel(rawSel), .rdActive(!diorN),
    .ddOut(ddOut), .ddOe(ddOe), .intrq(intrq), .cmdValid(cmdValid),
    .cmdByte(cmdByte), .cmdFeat(cmdFeat), .cmdDone(cmdDone),
    .rdData(rdData), .rdEmpty(rdEmpty), .rdPop(rdPop),
    .wrData(wrData), .wrFull(wrFull), .wrPush(wrPush)
  );

  a_r6_upper_needs_iocs16: assert property (@(posedge clk) disable iff (!rstN)
    (ddOe[DATA_W-1:BYTE_W] != '0) |-> !iocs16N);
  a_r5_invalid_floats: assert property (@(posedge clk) disable iff (!rstN)
    (cs0N == cs1N) |-> (ddOe == '0));

endmodule

// File: tb/sim_ata_taskfile.sv
module sim_ata_taskfile;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cs0N = 1'b1, cs1N = 1'b1;
  logic [2:0] da = '0;
  logic diorN = 1'b1, diowN = 1'b1;
  logic [15:0] ddIn = '0;
  logic [15:0] ddOut, ddOe, rdData, wrData;
  logic iocs16N, intrq, cmdValid, rdPop, wrPush, rdEmpty;
  logic [7:0] cmdByte, cmdFeat;
  logic cmdDone = 1'b0;
  logic wrFull = 1'b0;

  always #2 clk = ~clk;

  ata_taskfile u0 (
    .clk(clk), .rstN(rstN), .cs0N(cs0N), .cs1N(cs1N), .da(da),
    .diorN(diorN), .diowN(diowN), .ddIn(ddIn), .ddOut(ddOut), .ddOe(ddOe),
    .iocs16N(iocs16N), .intrq(intrq), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .cmdFeat(cmdFeat), .cmdDone(cmdDone), .rdData(rdData), .rdEmpty(rdEmpty),
    .rdPop(rdPop), .wrData(wrData), .wrFull(wrFull), .wrPush(wrPush)
  );

  // back-end models
  logic [15:0] rdMem [0:15];
  int rdTail = 0, rdHead = 0, popCount = 0, pushCount = 0, cmdCount = 0;
  logic [15:0] lastPush = '0;
  logic [7:0] lastCmd = '0;
  assign rdData  = rdMem[rdHead[3:0]];
  assign rdEmpty = (rdTail == rdHead);

  always @(posedge clk) begin
    if (rdPop) begin rdHead <= rdHead + 1; popCount <= popCount + 1; end
    if (wrPush) begin pushCount <= pushCount + 1; lastPush <= wrData; end
    if (cmdValid) begin cmdCount <= cmdCount + 1; lastCmd <= cmdByte; end
  end

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [7:0] expTf [2:6];
  logic [1:0] expErr = '0;
  bit expBsy = 0;

  function automatic logic [15:0] expStatus();
    bit drq;
    drq = (rdTail != rdHead) && !expBsy;
    return {8'h00, expBsy, 1'b1, 2'b00, drq, 2'b00, expErr != 2'b00};
  endfunction

  function automatic logic [15:0] expDevAddr(input logic [7:0] head);
    return {9'b0, 1'b1, ~head[3:0], head[4], ~head[4]};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic c0, input logic c1, input logic [2:0] a,
                           input logic [15:0] d);
    @(negedge clk);
    cs0N = c0; cs1N = c1; da = a; ddIn = d; diowN = 1'b0;
    repeat (4) @(negedge clk);
    diowN = 1'b1;
    repeat (4) @(negedge clk);
    cs0N = 1'b1; cs1N = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic hostRead(input logic c0, input logic c1, input logic [2:0] a,
                          output logic [15:0] d, output logic [15:0] oe,
                          output logic io16);
    @(negedge clk);
    cs0N = c0; cs1N = c1; da = a; diorN = 1'b0;
    repeat (4) @(negedge clk);
    d = ddOut; oe = ddOe; io16 = iocs16N;
    diorN = 1'b1;
    repeat (4) @(negedge clk);
    cs0N = 1'b1; cs1N = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulseDone();
    @(negedge clk); cmdDone = 1'b1;
    @(negedge clk); cmdDone = 1'b0;
    repeat (2) @(negedge clk);
    expBsy = 0;
  endtask

  task automatic loadRd(input logic [15:0] w);
    rdMem[rdTail[3:0]] = w;
    rdTail = rdTail + 1;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, oe;
    logic io;
    int p0;
    void'($urandom(32'h5EED));
    for (int i = 2; i <= 6; i++) expTf[i] = 8'h00;
    for (int i = 0; i < 16; i++) rdMem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check("R1 intrq after reset", {15'b0, intrq}, 16'h0);
    check("R1 bus released", ddOe, 16'h0);
    hostRead(0, 1, 3'd7, d, oe, io);
    check("R1 status after reset", d, 16'h0040);
    hostRead(0, 1, 3'd2, d, oe, io);
    check("R1 count after reset", d, 16'h0000);

    // R2 random task-file traffic
    for (int round = 0; round < 2; round++) begin
      for (int i = 0; i < 20; i++) begin
        int a;
        logic [7:0] v;
        a = 2 + int'($urandom % 5);
        v = 8'($urandom);
        hostWrite(0, 1, 3'(a), {8'($urandom), v});
        expTf[a] = v;
      end
      for (int a = 2; a <= 6; a++) begin
        hostRead(0, 1, 3'(a), d, oe, io);
        check("R2 register readback", d, {8'h00, expTf[a]});
        check("R2 byte enable mask", oe, 16'h00FF);
        check("R6 iocs16 high off data reg", {15'b0, io}, 16'h1);
      end
    end

    // R3 features vs error, status vs command
    hostWrite(0, 1, 3'd1, 16'h00A5);
    check("R3 features output", {8'h00, cmdFeat}, 16'h00A5);
    hostRead(0, 1, 3'd1, d, oe, io);
    check("R3 error read not features", d, {14'b0, expErr});

    // R9 command
    p0 = cmdCount;
    hostWrite(0, 1, 3'd7, 16'h00EC);
    expBsy = 1;
    check("R9 single command pulse", 16'(cmdCount - p0), 16'd1);
    check("R9 command byte", {8'h00, lastCmd}, 16'h00EC);
    hostRead(0, 1, 3'd7, d, oe, io);
    check("R9 busy status", d, 16'h00C0);
    pulseDone();
    check("R9 done raises intrq", {15'b0, intrq}, 16'h1);

    // R10 alternate status has no side effect
    hostRead(1, 0, 3'd6, d, oe, io);
    check("R10 alt status value", d, expStatus());
    check("R10 intrq kept after alt read", {15'b0, intrq}, 16'h1);
    hostRead(0, 1, 3'd7, d, oe, io);
    check("R10 status value", d, expStatus());
    check("R10 intrq cleared by status read", {15'b0, intrq}, 16'h0);

    // R11 mask holds the pending request
    hostWrite(1, 0, 3'd6, 16'h0002);
    hostWrite(0, 1, 3'd7, 16'h0020);
    expBsy = 1;
    pulseDone();
    hostRead(1, 0, 3'd6, d, oe, io);
    check("R11 intrq masked", {15'b0, intrq}, 16'h0);
    hostWrite(1, 0, 3'd6, 16'h0000);
    check("R11 pending reappears", {15'b0, intrq}, 16'h1);
    hostRead(0, 1, 3'd7, d, oe, io);
    check("R11 status read clears", {15'b0, intrq}, 16'h0);

    // R4 control block map
    hostWrite(0, 1, 3'd6, 16'h00B5);
    expTf[6] = 8'hB5;
    hostRead(1, 0, 3'd7, d, oe, io);
    check("R4 device address value", d, expDevAddr(8'hB5));
    check("R4 device address bit7 undriven", oe, 16'h007F);
    hostRead(1, 0, 3'd2, d, oe, io);
    check("R4 unused cs1 read floats", oe, 16'h0000);
    hostWrite(1, 0, 3'd2, 16'h0077);
    hostRead(0, 1, 3'd2, d, oe, io);
    check("R4 unused cs1 write ignored", d, {8'h00, expTf[2]});

    // R5 invalid selects
    hostRead(0, 0, 3'd2, d, oe, io);
    check("R5 both selects float", oe, 16'h0000);
    hostRead(1, 1, 3'd0, d, oe, io);
    check("R5 no select float", oe, 16'h0000);
    check("R6 iocs16 high with no select", {15'b0, io}, 16'h1);
    hostWrite(0, 0, 3'd3, {8'h00, ~expTf[3]});
    hostWrite(1, 1, 3'd3, {8'h00, ~expTf[3]});
    hostRead(0, 1, 3'd3, d, oe, io);
    check("R5 invalid writes ignored", d, {8'h00, expTf[3]});

    // R7 read FIFO words
    for (int i = 0; i < 4; i++) loadRd(16'($urandom));
    for (int i = 0; i < 4; i++) begin
      logic [15:0] w;
      w = rdMem[rdHead[3:0]];
      p0 = popCount;
      hostRead(0, 1, 3'd0, d, oe, io);
      check("R7 data word", d, w);
      check("R7 full width enable", oe, 16'hFFFF);
      check("R6 iocs16 low on data reg", {15'b0, io}, 16'h0);
      check("R7 one pop", 16'(popCount - p0), 16'd1);
    end
    hostRead(1, 0, 3'd0, d, oe, io);
    check("R6 iocs16 high for cs1 addr0", {15'b0, io}, 16'h1);
    p0 = popCount;
    hostRead(0, 1, 3'd0, d, oe, io);
    expErr[0] = 1'b1;
    check("R7 no pop when empty", 16'(popCount - p0), 16'd0);
    hostRead(0, 1, 3'd7, d, oe, io);
    check("R7 status error bit", d, 16'h0041);

    // R8 write FIFO
    for (int i = 0; i < 3; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      p0 = pushCount;
      hostWrite(0, 1, 3'd0, w);
      check("R8 one push", 16'(pushCount - p0), 16'd1);
      check("R8 pushed word", lastPush, w);
    end
    wrFull = 1'b1;
    p0 = pushCount;
    hostWrite(0, 1, 3'd0, 16'h1234);
    expErr[1] = 1'b1;
    check("R8 no push when full", 16'(pushCount - p0), 16'd0);
    hostRead(0, 1, 3'd1, d, oe, io);
    check("R8 error byte", d, {14'b0, expErr});
    wrFull = 1'b0;
    hostWrite(0, 1, 3'd7, 16'h0030);
    expBsy = 1; expErr = '0;
    hostRead(0, 1, 3'd1, d, oe, io);
    check("R9 command clears error", d, 16'h0000);
    pulseDone();
    hostRead(0, 1, 3'd7, d, oe, io);

    // R12 soft reset
    hostWrite(0, 1, 3'd2, 16'h005A);
    hostWrite(1, 0, 3'd6, 16'h0004);
    hostRead(0, 1, 3'd7, d, oe, io);
    check("R12 busy during reset", d, 16'h00C0);
    hostRead(0, 1, 3'd2, d, oe, io);
    check("R12 count cleared", d, 16'h0000);
    hostWrite(0, 1, 3'd2, 16'h0033);
    hostRead(0, 1, 3'd2, d, oe, io);
    check("R12 write ignored in reset", d, 16'h0000);
    p0 = cmdCount;
    hostWrite(0, 1, 3'd7, 16'h0090);
    check("R12 command ignored in reset", 16'(cmdCount - p0), 16'd0);
    hostWrite(1, 0, 3'd6, 16'h0000);
    hostRead(0, 1, 3'd7, d, oe, io);
    check("R12 ready after reset release", d, 16'h0040);
    check("R12 features cleared", {8'h00, cmdFeat}, 16'h0000);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule